// File: doc/BRIEF.md
# Three-Phase Stage Controller Pipeline

This block is a cycle-level model of a chain of stage controllers for a latch-free, bundled-data asynchronous pipeline. Each stage controller has two separate controls. `pc` drives the pull-up side and `eval` drives the pull-down side. Together they give three phases: evaluate, isolate (hold) and precharge. A stage's done flag rises once a matched delay of `DLY` cycles has elapsed in evaluate with valid input. Its own done then drops `eval` at once, so the stage isolates and ignores its inputs.

A stage may precharge only when two things are true: the following stage reports done, and the stage's "absorbed" bit shows that the following stage has taken this stage's current item. The absorbed bit clears when the stage starts to precharge. It sets again once the following stage's done is low. Because of this, adjacent stages never need an empty spacer between them. A chain of `STAGES` controllers therefore holds `STAGES` distinct items.

The chain talks four-phase at both ends. The producer raises `in_req` with data and drops it after `in_ack`. The consumer sees `out_valid` and `out_data`, raises `out_ack`, and drops `out_ack` once `out_valid` falls.

Top module: `tpc_pipe`

## Requirements
- R1: The phase of each stage is seen on {stage_pc, stage_eval} as evaluate = (1,1), isolate = (1,0) and precharge = (0,0). The pair (0,1) never occurs.
- R2: Each stage moves only in the order evaluate, isolate, precharge, evaluate. A phase may repeat before it advances.
- R3: While rst_n is low, every stage is in precharge with stage_done = 0 and stage_absorbed = 1, and out_valid = 0. After release, each stage spends DLY cycles in precharge and then enters evaluate.
- R4: A stage in evaluate whose upstream done (in_req for stage 0) is high sets its done flag on the DLY-th clock edge. On the same edge it leaves evaluate for isolate. An item given to an empty chain reaches out_valid STAGES*DLY edges after the first edge that samples in_req high.
- R5: A stage in isolate holds its item. Changes on its inputs (in_data and in_req for stage 0) have no effect, and out_data stays stable while out_valid is high.
- R6: A stage enters precharge only on the edge after it sees, in isolate, both the downstream done (out_ack for the last stage) and its absorbed bit high. With STAGES=4 and DLY=2, stage 0 enters precharge on the 2*DLY+1-th edge of a lone item's trip.
- R7: The absorbed bit clears on the edge where the stage enters precharge. It sets on an edge where the stage is not in precharge and the downstream done is low.
- R8: Precharge lasts DLY cycles and clears the stage's done flag as it ends.
- R9: With out_ack held low, the chain accepts exactly STAGES items. All stages then report done and isolate, in_ack stays high, and only the last stage's absorbed bit is set.
- R10: Items leave at out_data in the order they entered, with no loss and no duplication.
- R11: in_ack is stage 0's done, out_valid is the last stage's done, and out_ack acts as the downstream done of the last stage.
- R12: With CLEAR_ON_PRE=1, a stage's data output returns to zero when its precharge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset |
| in_req | input | 1 | Producer request: in_data is valid |
| in_data | input | WIDTH | Producer data |
| in_ack | output | 1 | Done flag of stage 0 |
| out_valid | output | 1 | Done flag of the last stage |
| out_data | output | WIDTH | Item held by the last stage |
| out_ack | input | 1 | Consumer done, downstream done of the last stage |
| stage_pc | output | STAGES | Per-stage precharge control (0 = precharging) |
| stage_eval | output | STAGES | Per-stage evaluate control |
| stage_absorbed | output | STAGES | Per-stage absorbed bit |
| stage_done | output | STAGES | Per-stage done flag |

## Verification
The bound checker watches every stage on every cycle for four things:
- the phase order;
- the precharge guard, which needs both the downstream done and the absorbed bit;
- the clearing of the absorbed bit on entry to precharge;
- the rise of done coinciding with the drop of eval, and evaluate directly following the fall of done.

It also checks that out_data holds while out_valid is high. Only the bench scenarios can show the rest:
- the exact latency and the edge on which precharge starts;
- that a stalled chain holds exactly STAGES distinct items and refuses more;
- that items come out in order and that inputs toggled during isolate are never taken.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   // Phase code is {pc, eval}; the bit positions are what the stage drives.
   typedef enum logic [1:0] {
      PH_PRE  = 2'b00,
      PH_ISO  = 2'b10,
      PH_EVAL = 2'b11
   } phase_e;

   function automatic int unsigned cnt_width(input int unsigned dly);
      return (dly > 1) ? $clog2(dly) : 1;
   endfunction
endpackage

// File: rtl/tpc_stage_ctrl.sv
module tpc_stage_ctrl #(
   parameter int unsigned DLY = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           up_done,
   input  logic           dn_done,
   output tpc_pkg::phase_e phase_o,
   output logic           done_o,
   output logic           absorbed_o,
   output logic           capture_o,
   output logic           clear_o
);
   import tpc_pkg::*;

   localparam int unsigned CW = cnt_width(DLY);
   localparam logic [CW-1:0] LAST = CW'(DLY - 1);

   phase_e        phase;
   logic [CW-1:0] cnt;
   logic          done;
   logic          absorbed;
   logic          at_last;

   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_PRE;
         cnt      <= '0;
         done     <= 1'b0;
         absorbed <= 1'b1;
      end else begin
         case (phase)
            PH_EVAL: begin
               if (!dn_done) absorbed <= 1'b1;
               if (up_done) begin
                  if (at_last) begin
                     phase <= PH_ISO;   // own done drops eval at once
                     done  <= 1'b1;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end else begin
                  cnt <= '0;
               end
            end
            PH_ISO: begin
               if (dn_done && absorbed) begin
                  phase    <= PH_PRE;
                  absorbed <= 1'b0;
               end else if (!dn_done) begin
                  absorbed <= 1'b1;
               end
            end
            PH_PRE: begin
               if (at_last) begin
                  phase <= PH_EVAL;
                  done  <= 1'b0;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: begin
               phase <= PH_PRE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign phase_o    = phase;
   assign done_o     = done;
   assign absorbed_o = absorbed;
   assign capture_o  = (phase == PH_EVAL) && up_done && at_last;
   assign clear_o    = (phase == PH_PRE) && at_last;
endmodule

// File: rtl/tpc_stage_data.sv
module tpc_stage_data #(
   parameter int unsigned WIDTH        = 8,
   parameter bit          CLEAR_ON_PRE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             clear,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q;

   generate
      if (CLEAR_ON_PRE) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= d_in;
            else if (clear)   q <= '0;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= d_in;
         end
      end
   endgenerate

   assign q_o = q;
endmodule

// File: rtl/tpc_pipe.sv
module tpc_pipe #(
   parameter int unsigned STAGES       = 4,
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned DLY          = 2,
   parameter bit          CLEAR_ON_PRE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_req,
   input  logic [WIDTH-1:0]  in_data,
   output logic              in_ack,
   output logic              out_valid,
   output logic [WIDTH-1:0]  out_data,
   input  logic              out_ack,
   output logic [STAGES-1:0] stage_pc,
   output logic [STAGES-1:0] stage_eval,
   output logic [STAGES-1:0] stage_absorbed,
   output logic [STAGES-1:0] stage_done
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpc_pipe: STAGES must be at least 2");
      end
      if (DLY < 1) begin : g_bad_dly
         $error("tpc_pipe: DLY must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tpc_pipe: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] done;
   logic [STAGES:0]   fwd;   // fwd[i] is the upstream done of stage i
   logic [STAGES:0]   bwd;   // bwd[i+1] is the downstream done of stage i
   logic [WIDTH-1:0]  dchain [0:STAGES];

   assign fwd       = {done, in_req};
   assign bwd       = {out_ack, done};
   assign dchain[0] = in_data;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         tpc_pkg::phase_e ph;
         logic            cap;
         logic            clr;
         logic            absd;

         tpc_stage_ctrl #(.DLY(DLY)) u_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .up_done    (fwd[i]),
            .dn_done    (bwd[i+1]),
            .phase_o    (ph),
            .done_o     (done[i]),
            .absorbed_o (absd),
            .capture_o  (cap),
            .clear_o    (clr)
         );

         tpc_stage_data #(.WIDTH(WIDTH), .CLEAR_ON_PRE(CLEAR_ON_PRE)) u_data (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (cap),
            .clear   (clr),
            .d_in    (dchain[i]),
            .q_o     (dchain[i+1])
         );

         assign stage_pc[i]       = ph[1];
         assign stage_eval[i]     = ph[0];
         assign stage_absorbed[i] = absd;
      end
   endgenerate

   assign stage_done = done;
   assign in_ack     = done[0];
   assign out_valid  = done[STAGES-1];
   assign out_data   = dchain[STAGES];
endmodule

// File: rtl/tpc_pipe_chk.sv
module tpc_pipe_chk #(
   parameter int unsigned STAGES = 4,
   parameter int unsigned WIDTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_ack,
   input logic              out_valid,
   input logic [WIDTH-1:0]  out_data,
   input logic [STAGES-1:0] stage_pc,
   input logic [STAGES-1:0] stage_eval,
   input logic [STAGES-1:0] stage_absorbed,
   input logic [STAGES-1:0] stage_done
);
   logic [STAGES:0] dn;
   assign dn = {out_ack, stage_done};

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_chk
         // R2
         eval_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_pc[i] && stage_eval[i]) |=> stage_pc[i]);
         // R2
         iso_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_pc[i] && !stage_eval[i]) |=> !stage_eval[i]);
         // R2
         pre_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !stage_pc[i] |=> (stage_eval[i] || !stage_pc[i]));
         // R4
         self_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stage_eval[i]) |-> $rose(stage_done[i]));
         // R4
         done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stage_done[i]) |-> $past(stage_eval[i]));
         // R6
         pre_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stage_pc[i]) |-> ($past(dn[i+1]) && $past(stage_absorbed[i])));
         // R7
         absorbed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stage_pc[i]) |-> !stage_absorbed[i]);
         // R8
         pre_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stage_done[i]) |-> ($past(!stage_pc[i]) && stage_pc[i] && stage_eval[i]));
      end
   endgenerate

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> $stable(out_data));
endmodule

bind tpc_pipe tpc_pipe_chk #(.STAGES(STAGES), .WIDTH(WIDTH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .out_ack        (out_ack),
   .out_valid      (out_valid),
   .out_data       (out_data),
   .stage_pc       (stage_pc),
   .stage_eval     (stage_eval),
   .stage_absorbed (stage_absorbed),
   .stage_done     (stage_done)
);

// File: tb/tpc_pipe_tb.sv
`timescale 1ns/1ps
module tpc_pipe_tb;
   localparam int unsigned STAGES = 4;
   localparam int unsigned WIDTH  = 8;
   localparam int unsigned DLY    = 2;
   localparam int NVEC = 12;
   localparam logic [WIDTH-1:0] VEC [NVEC] = '{
      8'h3C, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A,
      8'hA5, 8'h7E, 8'h10, 8'hC3, 8'h42, 8'h99};
   localparam logic [STAGES-1:0] ALL1 = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_req = 1'b0;
   logic [WIDTH-1:0]  in_data = '0;
   logic              in_ack;
   logic              out_valid;
   logic [WIDTH-1:0]  out_data;
   logic              out_ack = 1'b0;
   logic [STAGES-1:0] stage_pc, stage_eval, stage_absorbed, stage_done;

   int nchk = 0;
   int nfail = 0;
   logic sink_en = 1'b0;
   logic [WIDTH-1:0] rx_data [0:63];
   int rx_cnt = 0;

   always #2.5 clk = ~clk;

   tpc_pipe #(.STAGES(STAGES), .WIDTH(WIDTH), .DLY(DLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
      .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data),
      .out_ack(out_ack), .stage_pc(stage_pc), .stage_eval(stage_eval),
      .stage_absorbed(stage_absorbed), .stage_done(stage_done));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   task automatic send(input logic [WIDTH-1:0] v);
      @(negedge clk);
      while (in_ack) @(negedge clk);
      in_data = v;
      in_req  = 1'b1;
      do @(negedge clk); while (!in_ack);
      in_req = 1'b0;
   endtask

   // consumer: four-phase on out_valid / out_ack
   initial begin
      forever begin
         @(negedge clk);
         if (sink_en && out_valid && !out_ack) begin
            if (rx_cnt < 64) rx_data[rx_cnt] = out_data;
            rx_cnt++;
            out_ack = 1'b1;
         end else if (out_ack && !out_valid) begin
            out_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      int base;
      int t_rise, t_pcf, t_fall, t_out;

      // reset state
      repeat (3) @(negedge clk);
      check(stage_pc == '0,            "R3 pc in reset",       stage_pc, 0);
      check(stage_eval == '0,          "R3 eval in reset",     stage_eval, 0);
      check(stage_absorbed == ALL1,    "R3 absorbed in reset", stage_absorbed, ALL1);
      check(stage_done == '0,          "R3 done in reset",     stage_done, 0);
      check(!out_valid,                "R3 out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      repeat (DLY + 2) @(negedge clk);
      check(stage_pc == ALL1 && stage_eval == ALL1, "R3 R1 evaluate after reset",
            {stage_pc, stage_eval}, {ALL1, ALL1});
      check(!in_ack, "R11 in_ack idle", in_ack, 0);

      // single item timing
      sink_en = 1'b1;
      in_data = 8'hA5;
      in_req  = 1'b1;
      t_rise = 0; t_pcf = 0; t_fall = 0; t_out = 0;
      for (int k = 1; k <= 60; k++) begin
         @(posedge clk); #1;
         if (in_ack && t_rise == 0) begin
            t_rise = k;
            check(stage_pc[0] && !stage_eval[0], "R4 R1 isolate on done",
                  {stage_pc[0], stage_eval[0]}, 2'b10);
            in_req = 1'b0;
         end
         if (!stage_pc[0] && t_pcf == 0) t_pcf = k;
         if (t_rise != 0 && !in_ack && t_fall == 0) t_fall = k;
         if (out_valid && t_out == 0) t_out = k;
      end
      check(t_rise == DLY,            "R4 stage0 done edge",   t_rise, DLY);
      check(t_pcf == 2 * DLY + 1,     "R6 stage0 precharge edge", t_pcf, 2 * DLY + 1);
      check(t_fall - t_pcf == DLY,    "R8 precharge length",   t_fall - t_pcf, DLY);
      check(t_out == STAGES * DLY,    "R4 chain latency",      t_out, STAGES * DLY);
      check(rx_cnt == 1 && rx_data[0] == 8'hA5, "R10 single item", rx_data[0], 8'hA5);
      check(!out_valid && out_data == '0, "R12 data cleared", out_data, 0);

      // vector table walk
      base = rx_cnt;
      for (int i = 0; i < NVEC; i++) send(VEC[i]);
      while (rx_cnt < base + NVEC) @(negedge clk);
      for (int i = 0; i < NVEC; i++)
         check(rx_data[base + i] == VEC[i], "R10 stream order", rx_data[base + i], VEC[i]);
      while (stage_done != '0) @(negedge clk);

      // fill with the consumer stalled
      sink_en = 1'b0;
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      repeat (3 * DLY + 10) @(negedge clk);
      check($countones(stage_done) == STAGES, "R9 items stored", $countones(stage_done), STAGES);
      check(in_ack, "R9 R11 in_ack held", in_ack, 1);
      check(stage_pc == ALL1 && stage_eval == '0, "R9 R1 all isolate",
            {stage_pc, stage_eval}, {ALL1, {STAGES{1'b0}}});
      check(stage_absorbed == (STAGES'(1) << (STAGES - 1)), "R9 R7 absorbed pattern",
            stage_absorbed, STAGES'(1) << (STAGES - 1));
      check(stage_pc[STAGES-1], "R6 last stage waits for out_ack", stage_pc[STAGES-1], 1);
      check(out_valid && out_data == 8'h11, "R11 head item", out_data, 8'h11);

      // inputs toggled during isolate
      in_data = 8'hEE;
      in_req  = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         in_data = ~in_data;
      end
      check(stage_done == ALL1, "R5 done unchanged", stage_done, ALL1);
      check(out_data == 8'h11, "R5 head held", out_data, 8'h11);
      in_req = 1'b0;
      @(negedge clk);

      // drain
      base = rx_cnt;
      sink_en = 1'b1;
      while (rx_cnt < base + 4) @(negedge clk);
      check(rx_data[base]     == 8'h11, "R10 drain 0", rx_data[base],     8'h11);
      check(rx_data[base + 1] == 8'h22, "R10 drain 1", rx_data[base + 1], 8'h22);
      check(rx_data[base + 2] == 8'h33, "R10 drain 2", rx_data[base + 2], 8'h33);
      check(rx_data[base + 3] == 8'h44, "R10 drain 3", rx_data[base + 3], 8'h44);
      repeat (4 * DLY + 10) @(negedge clk);
      check(rx_cnt == base + 4, "R5 no extra item", rx_cnt - base, 4);
      check(stage_done == '0, "R8 all empty", stage_done, 0);
      check(stage_pc == ALL1 && stage_eval == ALL1, "R2 back to evaluate",
            {stage_pc, stage_eval}, {ALL1, ALL1});
      check(stage_absorbed == ALL1, "R7 absorbed set again", stage_absorbed, ALL1);

      summary();
      $finish;
   end
endmodule